// File: doc/BRIEF.md
# Keyed Non-Stoppable Watchdog Timer

This block is a watchdog counter that advances on a low-speed tick enable and begins counting as soon as synchronous reset is released. Software cannot halt it, and a stop-mode request has no effect on it. The tick arrives as a single-cycle enable that is already synchronous to the bus clock, so counting and clearing happen in one clock domain.

A small write bus reaches two registers. The mode register holds a 3-bit cycle field `n`, which selects a timeout of 2^(BASE_LOG2+n) ticks. Any write to the mode register also clears the count. The service register restarts the count only when it receives the key byte 8'hAC. Any other byte written there is treated as a fault.

When the timeout elapses, or when a wrong key is written, the block drives a reset output high for one bus clock. In that same cycle it returns its count and its cycle field to their reset values.

Top module: `wdog_keyed`

## Requirements
- R1: After synchronous reset, `wdt_rst` is low, the cycle field is 3'b111, and reading address 0 returns 8'h1F. That value has bits 2:0 set to the cycle field, bits 4:3 fixed at 2'b11 and bits 7:5 at zero. `bus_rdata` is registered: it shows the register selected by `bus_addr` one clock later. Address 1 reads 8'h00.
- R2: With cycle field n, `wdt_rst` rises in the clock after the 2^(BASE_LOG2+n)-th tick following a clear, provided no clearing write occurs in between.
- R3: Writing 8'hAC to address 1 (the service register) clears the count to zero, and counting resumes from zero.
- R4: A write to address 0 (the mode register) loads bits 2:0 into the cycle field and clears the count in the same clock.
- R5: Bits 4:3 of the mode register, which select the clock source, ignore written values and always read 2'b11. Bits 7:5 ignore written values and read zero.
- R6: `stop_req` has no effect: counting and timeout behave the same whether it is high or low.
- R7: Writing any byte other than 8'hAC to address 1 makes `wdt_rst` high in the next clock.
- R8: `wdt_rst` lasts exactly one clock. When it is high, the cycle field is back at 3'b111 and the count is zero.
- R9: A clearing write (the key to address 1, or any write to address 0) in the same clock as the terminal tick wins, and no reset is produced. A wrong key in that clock produces a single one-clock pulse.
- R10: The count advances only in clocks where `tick` is high. Idle clocks do not move it toward timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Low-speed count enable, one clock wide |
| stop_req | input | 1 | Stop-mode request, which does not affect the counter |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 1 | Register select: 0 = mode, 1 = service key |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data for `bus_addr` |
| wdt_rst | output | 1 | One-clock internal reset pulse |

## Verification
Two things can meet in one clock: a software write to the service or mode register, and the tick that would take the count to its terminal value. The bench runs the count to one tick short of the period. It then drives `tick` together with a correct key, then together with a mode write, and finally together with a wrong key. The scoreboard expects no pulse in the first two cases and exactly one pulse in the third. Any pulse that arrives early, late or twice is flagged. A full period then has to elapse again before the next expected pulse.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int          DATA_W    = 8;
  localparam int          CYC_W     = 3;
  localparam logic        ADDR_MODE = 1'b0;
  localparam logic        ADDR_SVC  = 1'b1;
  localparam logic [7:0]  SVC_KEY   = 8'hAC;
  localparam logic [1:0]  SRC_FIXED = 2'b11;
  localparam logic [CYC_W-1:0] CYC_RESET = '1;
endpackage

// File: rtl/wdog_regif.sv
module wdog_regif
  import wdog_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              fire,
  output logic [CYC_W-1:0]  cyc_q,
  output logic              clr,
  output logic              key_err,
  output logic [DATA_W-1:0] rdata_q
);
  logic wr_mode, wr_svc, key_ok;

  always_comb begin
    wr_mode = bus_wr && (bus_addr == ADDR_MODE);
    wr_svc  = bus_wr && (bus_addr == ADDR_SVC);
    key_ok  = (bus_wdata == SVC_KEY);
    clr     = wr_mode || (wr_svc && key_ok);
    key_err = wr_svc && !key_ok;
  end

  // Cycle field; source bits are not stored at all.
  always_ff @(posedge clk) begin
    if (rst || fire)  cyc_q <= CYC_RESET;
    else if (wr_mode) cyc_q <= bus_wdata[CYC_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)                         rdata_q <= '0;
    else if (bus_addr == ADDR_MODE)  rdata_q <= {{(DATA_W-CYC_W-2){1'b0}}, SRC_FIXED, cyc_q};
    else                             rdata_q <= '0;
  end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
  import wdog_pkg::*;
#(
  parameter int BASE_LOG2 = 11,
  parameter int CNT_W     = BASE_LOG2 + 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             clr,
  input  logic             fire,
  input  logic [CYC_W-1:0] cyc,
  output logic [CNT_W-1:0] cnt_q,
  output logic             term_hit
);
  logic [CNT_W-1:0] limit;
  logic [CYC_W-1:0] shift;

  always_comb begin
    shift    = CYC_RESET - cyc;
    limit    = {CNT_W{1'b1}} >> shift;
    term_hit = tick && !clr && (cnt_q == limit);
  end

  always_ff @(posedge clk) begin
    if (rst || clr || fire) cnt_q <= '0;
    else if (tick)          cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/wdog_rstgen.sv
module wdog_rstgen (
  input  logic clk,
  input  logic rst,
  input  logic key_err,
  input  logic term_hit,
  output logic fire,
  output logic pulse_q
);
  always_comb fire = key_err || term_hit;

  always_ff @(posedge clk) begin
    if (rst) pulse_q <= 1'b0;
    else     pulse_q <= fire;
  end
endmodule

// File: rtl/wdog_keyed.sv
module wdog_keyed
  import wdog_pkg::*;
#(
  parameter int BASE_LOG2 = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              stop_req,
  input  logic              bus_wr,
  input  logic              bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              wdt_rst
);
  localparam int CNT_W = BASE_LOG2 + 7;

  logic [CYC_W-1:0] cyc_q;
  logic [CNT_W-1:0] cnt_q;
  logic clr, key_err, term_hit, fire;
  logic stop_unused;

  // The stop request is accepted but deliberately has no path to the counter.
  assign stop_unused = stop_req;

  wdog_regif u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .fire(fire), .cyc_q(cyc_q), .clr(clr),
    .key_err(key_err), .rdata_q(bus_rdata)
  );

  wdog_counter #(.BASE_LOG2(BASE_LOG2), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .clr(clr), .fire(fire),
    .cyc(cyc_q), .cnt_q(cnt_q), .term_hit(term_hit)
  );

  wdog_rstgen u_rgen (
    .clk(clk), .rst(rst), .key_err(key_err), .term_hit(term_hit),
    .fire(fire), .pulse_q(wdt_rst)
  );
endmodule

// File: rtl/wdog_keyed_chk.sv
module wdog_keyed_chk
  import wdog_pkg::*;
#(
  parameter int CNT_W = 18
) (
  input logic              clk,
  input logic              rst,
  input logic              tick,
  input logic              bus_wr,
  input logic              bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              wdt_rst,
  input logic [CNT_W-1:0]  cnt,
  input logic [CYC_W-1:0]  cyc
);
  assert_bad_key_R7: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_SVC && bus_wdata != SVC_KEY) |=> wdt_rst);

  assert_one_clock_R8: assert property (@(posedge clk) disable iff (rst)
    wdt_rst |=> !wdt_rst);

  assert_back_to_reset_R8: assert property (@(posedge clk) disable iff (rst)
    wdt_rst |-> (cyc == CYC_RESET && cnt == '0));

  assert_mode_clears_R4: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_MODE) |=> (cnt == '0));

  assert_key_clears_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_SVC && bus_wdata == SVC_KEY) |=> (cnt == '0 && !wdt_rst));

  assert_tick_counts_R6: assert property (@(posedge clk) disable iff (rst)
    (tick && !bus_wr) |=> (wdt_rst || cnt == CNT_W'($past(cnt) + 1'b1)));

  assert_idle_holds_R10: assert property (@(posedge clk) disable iff (rst)
    (!tick && !bus_wr) |=> ($stable(cnt) && !wdt_rst));
endmodule

bind wdog_keyed wdog_keyed_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .wdt_rst(wdt_rst), .cnt(cnt_q), .cyc(cyc_q)
);

// File: tb/wdog_keyed_tb.sv
module wdog_keyed_tb;
  localparam int CLK_PERIOD = 10;
  localparam int BASE       = 2;
  localparam int WD_LIMIT   = 20000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0, stop_req = 1'b0, bus_wr = 1'b0, bus_addr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic wdt_rst;

  int cyc_n = 0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int    exp_at[$];
  string exp_req[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc_n <= cyc_n + 1;

  wdog_keyed #(.BASE_LOG2(BASE)) u_dut (
    .clk(clk), .rst(rst), .tick(tick), .stop_req(stop_req), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wdt_rst(wdt_rst)
  );

  task automatic finish_up();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // Monitor: compares observed reset pulses against the expected queue.
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (exp_at.size() > 0 && exp_at[0] < cyc_n) begin
        checks++; errors++;
        $display("FAIL %s wdt_rst=0 at cycle %0d expected 1", exp_req[0], exp_at[0]);
        void'(exp_at.pop_front()); void'(exp_req.pop_front());
      end
      if (wdt_rst) begin
        checks++;
        if (exp_at.size() > 0 && exp_at[0] == cyc_n) begin
          void'(exp_at.pop_front()); void'(exp_req.pop_front());
        end else begin
          errors++;
          $display("FAIL R2/R8/R9 wdt_rst=1 at cycle %0d expected 0", cyc_n);
        end
      end
    end
  end

  always @(posedge clk) begin
    if (!done && cyc_n > WD_LIMIT) begin
      checks++; errors++;
      $display("FAIL watchdog: cycle=%0d expected <= %0d", cyc_n, WD_LIMIT);
      finish_up();
    end
  end

  task automatic step(); @(negedge clk); endtask

  task automatic expect_pulse(string req);
    exp_at.push_back(cyc_n + 1); exp_req.push_back(req);
  endtask

  task automatic ticks(int n, bit last_fires, string req);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      if (last_fires && i == n-1) expect_pulse(req);
      step();
      tick = 1'b0;
      step();
    end
  endtask

  task automatic wr(logic a, logic [7:0] d, bit fires, string req);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    if (fires) expect_pulse(req);
    step();
    bus_wr = 1'b0;
  endtask

  task automatic tick_wr(logic a, logic [7:0] d, bit fires, string req);
    tick = 1'b1;
    wr(a, d, fires, req);
    tick = 1'b0;
    step();
  endtask

  task automatic rd_check(logic a, logic [7:0] expv, string req);
    bus_addr = a;
    step();
    checks++;
    if (bus_rdata !== expv) begin
      errors++;
      $display("FAIL %s rdata=%h expected %h", req, bus_rdata, expv);
    end
  endtask

  initial begin
    repeat (3) step();
    rst = 1'b0;
    step();
    checks++;
    if (wdt_rst !== 1'b0) begin errors++; $display("FAIL R1 wdt_rst=%b expected 0", wdt_rst); end
    rd_check(1'b0, 8'h1F, "R1");
    rd_check(1'b1, 8'h00, "R1");

    // R4, R5: cycle 2 with source bits written as 00 and top bits as 111
    wr(1'b0, 8'hE2, 0, "R4");
    rd_check(1'b0, 8'h1A, "R5");
    // R2: n=2 gives 16 ticks
    ticks(16, 1, "R2");
    rd_check(1'b0, 8'h1F, "R8");

    // R2: n=0 gives 4 ticks
    wr(1'b0, 8'h00, 0, "R4");
    ticks(4, 1, "R2");

    // R3 with R6: key restarts the count while stop is requested
    stop_req = 1'b1;
    wr(1'b0, 8'h00, 0, "R4");
    ticks(3, 0, "R3");
    wr(1'b1, 8'hAC, 0, "R3");
    ticks(3, 0, "R3");
    ticks(1, 1, "R3");
    stop_req = 1'b0;

    // R7: wrong key, then R8 readback
    wr(1'b1, 8'h55, 1, "R7");
    rd_check(1'b0, 8'h1F, "R8");

    // R9: key in the terminal-tick clock wins
    wr(1'b0, 8'h00, 0, "R4");
    ticks(3, 0, "R9");
    tick_wr(1'b1, 8'hAC, 0, "R9");
    ticks(3, 0, "R9");
    ticks(1, 1, "R9");
    // R9: mode write in the terminal-tick clock wins and sets n=1 (8 ticks)
    wr(1'b0, 8'h00, 0, "R4");
    ticks(3, 0, "R9");
    tick_wr(1'b0, 8'h01, 0, "R9");
    rd_check(1'b0, 8'h19, "R4");
    ticks(7, 0, "R9");
    ticks(1, 1, "R9");
    // R9: wrong key together with terminal tick gives a single pulse
    wr(1'b0, 8'h00, 0, "R4");
    ticks(3, 0, "R9");
    tick_wr(1'b1, 8'h00, 1, "R9");
    rd_check(1'b0, 8'h1F, "R8");

    // R10: idle clocks do not count
    wr(1'b0, 8'h00, 0, "R4");
    ticks(3, 0, "R10");
    repeat (40) step();
    ticks(1, 1, "R10");

    // R2 longest period from reset value, with R6 stop held
    stop_req = 1'b1;
    ticks(512, 1, "R2");
    stop_req = 1'b0;
    repeat (4) step();

    checks++;
    if (exp_at.size() != 0) begin
      errors++;
      $display("FAIL R2 pending pulses=%0d expected 0", exp_at.size());
    end
    finish_up();
  end
endmodule